// File: doc/BRIEF.md
# Pipelined Read Data Output Stage

This block is the data-out end of a common-I/O synchronous memory. A cycle decoder upstream reports, for each clock cycle, whether the access registered for that cycle is a read, a write or nothing. The memory core returns read data in the same cycle. This block registers that data and presents it on the data-out port one clock later. It also produces a drive-enable that an external three-state buffer uses to decide whether the shared bus is driven.

The drive-enable combines three things: the asynchronous active-low output enable, the registered read state, and a set of masking rules. The masking rules cover three cases:
- the first data cycle of a read that starts straight out of an idle/deselected cycle;
- any cycle whose decoder status is a write;
- sleep.

On the write side, bus data and the per-lane byte mask from the write controller are registered on the rising edge and handed to the core with a one-cycle valid flag. Data width, lane width and the reset style of the data registers are parameters.

Top module: `pipe_rd_out`

## Requirements
- R1: While `rst_n` is low, `drive_en`, `wr_valid` and `wr_lane_q` are 0. With the default `RESET_DATA=1`, `dout` is also 0.
- R2: Status `cyc_kind` is encoded as 0 = deselected, 1 = read, 2 = write, 3 = parked (handled like deselected). When status 1 is sampled at a rising edge with `sleep` low, `dout` equals the `core_rdata` sampled at that edge from that edge until the next.
- R3: `drive_en` is 0 whenever `oe_n` is 1, with no clock edge needed. `dout` keeps its value.
- R4: A read sampled directly after a cycle that was deselected, parked or asleep (and the first read after reset) leaves `drive_en` at 0 for its whole data cycle, whatever `oe_n` is.
- R5: `drive_en` is 0 in any cycle whose current `cyc_kind` is 2 (write), whatever `oe_n` is. It stays 0 in the data cycle after a sampled write.
- R6: When status 0 or 3 is sampled, `drive_en` is 0 from that edge until the next edge.
- R7: Reads sampled on consecutive edges give a new `dout` value every cycle. Every read after the first is driven when `oe_n` is 0.
- R8: `drive_en` is 0 while `sleep` is 1. A sampled cycle with `sleep` high counts as deselected: `dout` is unchanged and `wr_valid` is 0.
- R9: When status 2 is sampled with `sleep` low, `wr_data` = `bus_din`, `wr_lane_q` = `wr_lane_en` and `wr_valid` = 1 for the following cycle. Otherwise `wr_valid` is 0 and `wr_data` and `wr_lane_q` hold.
- R10: An edge at which no read is accepted leaves `dout` unchanged.
- R11: `drive_en` is 1 exactly when all of these hold: `oe_n` is 0, `sleep` is 0, the current `cyc_kind` is not 2, and the last edge accepted a read that R4 does not mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_kind | input | 2 | Decoder status of the current access (0 deselect, 1 read, 2 write, 3 parked) |
| core_rdata | input | DATA_W | Read data from the memory core for the current access |
| oe_n | input | 1 | Asynchronous active-low output enable |
| sleep | input | 1 | Active-high low-activity request |
| bus_din | input | DATA_W | Data seen on the shared bus |
| wr_lane_en | input | DATA_W/LANE_W | Byte-lane write mask from the write controller |
| dout | output | DATA_W | Registered read data |
| drive_en | output | 1 | Bus drive enable for the external three-state buffer |
| wr_data | output | DATA_W | Registered write data to the core |
| wr_lane_q | output | DATA_W/LANE_W | Registered byte-lane mask to the core |
| wr_valid | output | 1 | Registered write strobe to the core |

## Verification
The bench targets the following corner cases:
- A read that follows a deselected, parked or sleeping cycle. A design that drops the first-cycle mask drives stale-timing data onto a bus another bank may still hold.
- A write status arriving while a read result is on the bus. A design that gates only on the registered state fights the incoming write data for one cycle.
- Sleep in the middle of a read stream. A design that still accepts accesses would overwrite the held output or raise a spurious write strobe.
- Back-to-back reads, and reads following writes. A design that masks too often loses throughput; one that loads on the wrong edge shows data one cycle late.

// File: rtl/rdo_pkg.sv
package rdo_pkg;
   typedef enum logic [1:0] {
      CYC_IDLE  = 2'd0,
      CYC_READ  = 2'd1,
      CYC_WRITE = 2'd2,
      CYC_PARK  = 2'd3
   } cyc_e;
endpackage

// File: rtl/rdo_ctrl.sv
module rdo_ctrl
   import rdo_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] cyc_kind,
   input  logic       sleep,
   output logic       ld_rd,
   output logic       ld_wr,
   output logic       rd_q,
   output logic       mask_q,
   output logic       wr_valid
);
   cyc_e kind;
   logic was_off;

   assign kind  = cyc_e'(cyc_kind);
   assign ld_rd = !sleep && (kind == CYC_READ);
   assign ld_wr = !sleep && (kind == CYC_WRITE);

   // was_off remembers whether the last sampled cycle selected the device
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q     <= 1'b0;
         mask_q   <= 1'b0;
         was_off  <= 1'b1;
         wr_valid <= 1'b0;
      end else begin
         rd_q     <= ld_rd;
         mask_q   <= ld_rd && was_off;
         was_off  <= !(ld_rd || ld_wr);
         wr_valid <= ld_wr;
      end
   end
endmodule

// File: rtl/rdo_lane.sv
module rdo_lane #(
   parameter int LANE_W     = 8,
   parameter bit RESET_DATA = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_rd,
   input  logic              ld_wr,
   input  logic [LANE_W-1:0] rd_in,
   input  logic [LANE_W-1:0] wr_in,
   input  logic              en_in,
   output logic [LANE_W-1:0] rd_out,
   output logic [LANE_W-1:0] wr_out,
   output logic              en_out
);
   generate
      if (RESET_DATA) begin : g_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rd_out <= '0;
               wr_out <= '0;
            end else begin
               if (ld_rd) rd_out <= rd_in;
               if (ld_wr) wr_out <= wr_in;
            end
         end
      end else begin : g_norst
         always_ff @(posedge clk) begin
            if (ld_rd) rd_out <= rd_in;
            if (ld_wr) wr_out <= wr_in;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     en_out <= 1'b0;
      else if (ld_wr) en_out <= en_in;
   end
endmodule

// File: rtl/rdo_gate.sv
module rdo_gate
   import rdo_pkg::*;
(
   input  logic       oe_n,
   input  logic       sleep,
   input  logic [1:0] cyc_kind,
   input  logic       rd_q,
   input  logic       mask_q,
   output logic       drive_en
);
   logic blocked;

   always_comb begin
      blocked  = oe_n || sleep || (cyc_e'(cyc_kind) == CYC_WRITE) || mask_q;
      drive_en = rd_q && !blocked;
   end
endmodule

// File: rtl/pipe_rd_out.sv
module pipe_rd_out #(
   parameter int DATA_W     = 32,
   parameter int LANE_W     = 8,
   parameter bit RESET_DATA = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [1:0]                 cyc_kind,
   input  logic [DATA_W-1:0]          core_rdata,
   input  logic                       oe_n,
   input  logic                       sleep,
   input  logic [DATA_W-1:0]          bus_din,
   input  logic [DATA_W/LANE_W-1:0]   wr_lane_en,
   output logic [DATA_W-1:0]          dout,
   output logic                       drive_en,
   output logic [DATA_W-1:0]          wr_data,
   output logic [DATA_W/LANE_W-1:0]   wr_lane_q,
   output logic                       wr_valid
);
   localparam int NLANE = DATA_W / LANE_W;

   generate
      if (LANE_W < 1 || DATA_W % LANE_W != 0) begin : g_bad_width
         $error("pipe_rd_out: DATA_W must be a whole multiple of LANE_W");
      end
   endgenerate

   logic ld_rd, ld_wr, rd_q, mask_q;

   rdo_ctrl u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .cyc_kind (cyc_kind),
      .sleep    (sleep),
      .ld_rd    (ld_rd),
      .ld_wr    (ld_wr),
      .rd_q     (rd_q),
      .mask_q   (mask_q),
      .wr_valid (wr_valid)
   );

   for (genvar g = 0; g < NLANE; g++) begin : g_lane
      rdo_lane #(.LANE_W(LANE_W), .RESET_DATA(RESET_DATA)) u_lane (
         .clk    (clk),
         .rst_n  (rst_n),
         .ld_rd  (ld_rd),
         .ld_wr  (ld_wr),
         .rd_in  (core_rdata[g*LANE_W +: LANE_W]),
         .wr_in  (bus_din[g*LANE_W +: LANE_W]),
         .en_in  (wr_lane_en[g]),
         .rd_out (dout[g*LANE_W +: LANE_W]),
         .wr_out (wr_data[g*LANE_W +: LANE_W]),
         .en_out (wr_lane_q[g])
      );
   end

   rdo_gate u_gate (
      .oe_n     (oe_n),
      .sleep    (sleep),
      .cyc_kind (cyc_kind),
      .rd_q     (rd_q),
      .mask_q   (mask_q),
      .drive_en (drive_en)
   );
endmodule

// File: rtl/pipe_rd_out_chk.sv
module pipe_rd_out_chk #(
   parameter int DATA_W = 32,
   parameter int NLANE  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        cyc_kind,
   input logic [DATA_W-1:0] core_rdata,
   input logic              oe_n,
   input logic              sleep,
   input logic [DATA_W-1:0] bus_din,
   input logic [NLANE-1:0]  wr_lane_en,
   input logic [DATA_W-1:0] dout,
   input logic              drive_en,
   input logic [DATA_W-1:0] wr_data,
   input logic [NLANE-1:0]  wr_lane_q,
   input logic              wr_valid
);
   always_comb begin
      if (!rst_n) p_reset_quiet_r1: assert (!drive_en && !wr_valid && wr_lane_q == '0);
   end

   p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_kind == 2'd1 && !sleep) |=> dout == $past(core_rdata));

   p_oe_hiz_r3: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n |-> !drive_en);

   p_first_masked_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_kind == 2'd0) ##1 (cyc_kind == 2'd1) |=> !drive_en);

   p_write_hiz_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_kind == 2'd2) |-> !drive_en);

   p_desel_hiz_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_kind == 2'd0 || cyc_kind == 2'd3) |=> !drive_en);

   p_sleep_hiz_r8: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |-> !drive_en);

   p_wcap_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_kind == 2'd2 && !sleep) |=> wr_valid && wr_data == $past(bus_din)
                                        && wr_lane_q == $past(wr_lane_en));

   p_no_wstrobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(cyc_kind == 2'd2 && !sleep) |=> !wr_valid);

   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_kind != 2'd1 || sleep) |=> $stable(dout));
endmodule

bind pipe_rd_out pipe_rd_out_chk #(.DATA_W(DATA_W), .NLANE(DATA_W / LANE_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cyc_kind   (cyc_kind),
   .core_rdata (core_rdata),
   .oe_n       (oe_n),
   .sleep      (sleep),
   .bus_din    (bus_din),
   .wr_lane_en (wr_lane_en),
   .dout       (dout),
   .drive_en   (drive_en),
   .wr_data    (wr_data),
   .wr_lane_q  (wr_lane_q),
   .wr_valid   (wr_valid)
);

// File: tb/pipe_rd_out_bench.sv
`timescale 1ns/1ps
module pipe_rd_out_bench;
   localparam int DW = 32;
   localparam int NL = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    cyc_kind = 2'd0;
   logic [DW-1:0] core_rdata = '0;
   logic          oe_n = 1'b1;
   logic          sleep = 1'b0;
   logic [DW-1:0] bus_din = '0;
   logic [NL-1:0] wr_lane_en = '0;
   logic [DW-1:0] dout, wr_data;
   logic          drive_en, wr_valid;
   logic [NL-1:0] wr_lane_q;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   // expected-state model built from the requirements
   logic [DW-1:0] m_dout = '0, m_wd = '0;
   logic [NL-1:0] m_wl = '0;
   logic m_rd = 0, m_mask = 0, m_off = 1, m_wv = 0;

   always #4 clk = ~clk;

   pipe_rd_out u_pipe_rd_out (
      .clk(clk), .rst_n(rst_n), .cyc_kind(cyc_kind), .core_rdata(core_rdata),
      .oe_n(oe_n), .sleep(sleep), .bus_din(bus_din), .wr_lane_en(wr_lane_en),
      .dout(dout), .drive_en(drive_en), .wr_data(wr_data),
      .wr_lane_q(wr_lane_q), .wr_valid(wr_valid)
   );

   task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic exp_drive();
      return !oe_n && !sleep && cyc_kind != 2'd2 && m_rd && !m_mask;
   endfunction

   function automatic string drive_tag();
      if (sleep)               return "R8 sleep hiz";
      if (cyc_kind == 2'd2)    return "R5 write hiz";
      if (oe_n)                return "R3 oe hiz";
      if (m_mask)              return "R4 first read masked";
      if (!m_rd)               return "R6 deselect hiz";
      return "R11 drive";
   endfunction

   task automatic step(input logic [1:0] k, input logic [DW-1:0] rd, input logic oe,
                       input logic slp, input logic [DW-1:0] din, input logic [NL-1:0] ln);
      logic acc_rd, acc_wr;
      cyc_kind = k; core_rdata = rd; oe_n = oe; sleep = slp; bus_din = din; wr_lane_en = ln;
      #1;
      chk(drive_tag(), DW'(drive_en), DW'(exp_drive()));
      @(posedge clk);
      acc_rd = !slp && k == 2'd1;
      acc_wr = !slp && k == 2'd2;
      m_mask = acc_rd && m_off;
      m_rd   = acc_rd;
      m_off  = !(acc_rd || acc_wr);
      m_wv   = acc_wr;
      if (acc_rd) m_dout = rd;
      if (acc_wr) begin m_wd = din; m_wl = ln; end
      @(negedge clk);
      chk(acc_rd ? "R2 read latency" : "R10 dout hold", dout, m_dout);
      chk(drive_tag(), DW'(drive_en), DW'(exp_drive()));
      chk("R9 write strobe", DW'(wr_valid), DW'(m_wv));
      chk("R9 write data", wr_data, m_wd);
      chk("R9 write lanes", DW'(wr_lane_q), DW'(m_wl));
   endtask

   initial begin
      #(200000 * 8);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      int seed;
      seed = $urandom(32'd1234);
      repeat (3) @(negedge clk);
      chk("R1 reset drive", DW'(drive_en), '0);
      chk("R1 reset dout", dout, '0);
      chk("R1 reset wr_valid", DW'(wr_valid), '0);
      chk("R1 reset lanes", DW'(wr_lane_q), '0);
      rst_n = 1'b1;

      // first read after reset is masked (R4), the next one drives (R7)
      step(2'd1, 32'hAAAA_0001, 1'b0, 1'b0, '0, '0);
      chk("R4 masked first read", DW'(drive_en), '0);
      step(2'd1, 32'hAAAA_0002, 1'b0, 1'b0, '0, '0);
      chk("R7 back-to-back data", dout, 32'hAAAA_0002);
      chk("R7 back-to-back drive", DW'(drive_en), 32'd1);
      step(2'd1, 32'hAAAA_0003, 1'b1, 1'b0, '0, '0);
      chk("R3 oe high", DW'(drive_en), '0);
      oe_n = 1'b0; #1;
      chk("R3 oe low async", DW'(drive_en), 32'd1);
      step(2'd2, '0, 1'b0, 1'b0, 32'h1234_5678, 4'b0101);
      chk("R9 captured", wr_data, 32'h1234_5678);
      step(2'd1, 32'hBBBB_0001, 1'b0, 1'b0, '0, '0);
      chk("R11 read after write drives", DW'(drive_en), 32'd1);
      step(2'd3, 32'hDEAD_BEEF, 1'b0, 1'b0, '0, '0);
      chk("R6 parked hiz", DW'(drive_en), '0);
      step(2'd1, 32'hCCCC_0001, 1'b0, 1'b0, '0, '0);
      step(2'd1, 32'hCCCC_0002, 1'b0, 1'b1, '0, '0);
      chk("R8 sleep holds dout", dout, 32'hCCCC_0001);
      step(2'd2, '0, 1'b0, 1'b1, 32'hFFFF_FFFF, 4'b1111);
      chk("R8 sleep no write", DW'(wr_valid), '0);
      step(2'd1, 32'hCCCC_0003, 1'b0, 1'b0, '0, '0);
      chk("R4 read after sleep masked", DW'(drive_en), '0);

      for (int i = 0; i < 600; i++) begin
         logic [1:0] k;
         k = 2'($urandom_range(0, 3));
         step(k, $urandom, 1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 7) == 0),
              $urandom, 4'($urandom));
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule